// File: doc/BRIEF.md
# Memory encryption region controller

This block sits in front of an external memory window and decides, for every memory address offered to it, whether the access may travel in plain text or has to be routed through an encryption path. It keeps one protected window, which is 64 KiB aligned and includes both of its bounds. It also holds a 128-bit master key that is passed on to a cipher datapath outside the block, together with the sticky lock bits that freeze the configuration once boot software is done with it.

Software reaches the block over a simple 32-bit register bus. A write is one cycle with a write strobe. A read presents a read strobe and receives the data on `reg_rdata` one clock later. Each access also carries a privilege flag. The lookup port is purely combinational. It turns `lk_addr` into `lk_encrypt` within the same cycle. A fuse-style input, `enc_off`, reports that the encryption hardware is unusable, and it forces every address to bypass.

Byte offsets on the register bus: 0x00 control, 0x04 status, 0x0C privilege, 0x10 window control, 0x14 window low bound, 0x18 window high bound, and 0x20, 0x24, 0x28, 0x2C for key words 0 to 3. Any other offset reads back zero and ignores writes.

Top module: `mem_crypt_region_ctrl`

## Requirements
- R1: In the control register (0x00), bit 0 is the global lock and bit 1 is the key lock. Writing a 1 sets the bit. Writing a 0 has no effect. Only reset clears either bit, and both read back as written.
- R2: The status register (0x04) reads key-valid at bit 0 and the state of `enc_off` at bit 4. All other bits read zero.
- R3: The window control register (0x10) stores enable at bit 0 and encrypt-select at bit 15, and reads them back at the same positions.
- R4: The low (0x14) and high (0x18) bound registers store only bits 31:16. On read, bits 31:30 and 15:0 return zero.
- R5: When the window is active, `lk_encrypt` is 1 exactly when `lk_addr[31:16]` lies between the stored low and high fields, with both ends included. The high field therefore covers its whole 64 KiB block. The result appears in the same cycle as the address.
- R6: `lk_encrypt` is 0 for every address when the enable bit is clear, when encrypt-select is clear, or when `enc_off` is 1.
- R7: Key words go to 0x20, 0x24, 0x28 and 0x2C. Word n appears on `master_key[32n+31:32n]`. Key-valid becomes 1 in the cycle after the last of the four words has been written. Key registers read back zero.
- R8: Key-valid is 0 after reset. A key write made while the key is valid clears key-valid, and it stays 0 until all four words have been written again.
- R9: While the key lock is set, key-word writes are ignored, so `master_key` and key-valid do not change.
- R10: The privilege register (0x0C) holds its control at bit 0. While that bit is set, any access with `reg_priv`=0 is ignored on write and reads back zero.
- R11: While the global lock is set, writes to the window, privilege and key registers are ignored. Reads still work, and the control register can still be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_priv | input | 1 | Access is privileged |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| enc_off | input | 1 | Encryption hardware unusable |
| lk_addr | input | 32 | Memory address to classify |
| lk_encrypt | output | 1 | 1 = encrypt path, 0 = bypass |
| master_key | output | 128 | Master key towards the cipher datapath |

## Verification
The lookup is tried with a table of addresses placed around the window. The table includes the last byte below the low bound, the first byte of the low block, an address inside the window, the last byte of the high block and the first byte above it. This tells an inclusive compare apart from an exclusive one, and shows whether the low 16 address bits are wrongly taken into account. It also includes addresses whose bits 31:30 differ from the programmed bounds, which shows that the stored bounds keep their top bits even though reads mask them. Separate patterns clear enable, clear encrypt-select and raise `enc_off` one at a time, so each of the three gating conditions is shown to act on its own. The key tests stop after three words and also start a second sequence, which separates "all four written" from "some written".

// File: rtl/mcr_pkg.sv
// Package: shared offsets and bit positions for the memory encryption
// region controller. Assumes 32-bit registers on a byte-addressed bus.
package mcr_pkg;
    localparam int DATA_W    = 32;
    localparam int KEY_WORDS = 4;
    localparam int BOUND_LSB = 16;
    localparam int BOUND_W   = DATA_W - BOUND_LSB;

    // word indices (byte offset / 4)
    localparam logic [5:0] W_CTRL = 6'd0;
    localparam logic [5:0] W_STAT = 6'd1;
    localparam logic [5:0] W_PRIV = 6'd3;
    localparam logic [5:0] W_WCTL = 6'd4;
    localparam logic [5:0] W_WLO  = 6'd5;
    localparam logic [5:0] W_WHI  = 6'd6;
    localparam logic [5:0] W_KEY0 = 6'd8;

    localparam int B_GLOCK  = 0;
    localparam int B_KLOCK  = 1;
    localparam int B_KVALID = 0;
    localparam int B_ENCOFF = 4;
    localparam int B_WEN    = 0;
    localparam int B_WENC   = 15;
    localparam int B_PRIV   = 0;
endpackage

// File: rtl/mcr_keystore.sv
// Module: master key storage with the key-valid tracker.
// Assumes wr_en is already gated by every lock and privilege rule.
module mcr_keystore #(
    parameter int KEY_WORDS = 4,
    parameter int DATA_W    = 32,
    localparam int SEL_W    = $clog2(KEY_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            word_sel,
    input  logic [DATA_W-1:0]           wdata,
    output logic [KEY_WORDS*DATA_W-1:0] key,
    output logic                        valid
);
    logic [KEY_WORDS-1:0] seen_q;

    // per-word key storage
    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                key[g*DATA_W +: DATA_W] <= '0;
            else if (wr_en && word_sel == SEL_W'(g))
                key[g*DATA_W +: DATA_W] <= wdata;
        end
    end

    // track which words were written in the current sequence
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= '0;
        else if (wr_en) begin
            if (valid)
                seen_q <= KEY_WORDS'(1) << word_sel;
            else
                seen_q <= seen_q | (KEY_WORDS'(1) << word_sel);
        end
    end

    assign valid = &seen_q;

    // R7
    // key-valid may only rise right after a key word write
    kvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(wr_en));
endmodule

// File: rtl/mcr_region_match.sv
// Module: combinational classifier of a memory address against the window.
// Assumes bounds hold address bits 31:16 and both ends are inclusive.
module mcr_region_match #(
    parameter int ADDR_W    = 32,
    parameter int BOUND_LSB = 16,
    localparam int BOUND_W  = ADDR_W - BOUND_LSB
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BOUND_W-1:0] lo,
    input  logic [BOUND_W-1:0] hi,
    input  logic               active,
    output logic               hit
);
    logic [BOUND_W-1:0] blk;

    // compare the block number with both bounds
    always_comb begin
        blk = addr[ADDR_W-1:BOUND_LSB];
        hit = active && (blk >= lo) && (blk <= hi);
    end
endmodule

// File: rtl/mcr_regfile.sv
// Module: register bank with lock, privilege and read-back rules.
// Assumes one access per cycle; reads return data one cycle later.
module mcr_regfile
    import mcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic               reg_priv,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               enc_off,
    input  logic               key_valid,
    output logic               key_wr,
    output logic [1:0]         key_sel,
    output logic               win_en,
    output logic               win_enc,
    output logic [BOUND_W-1:0] win_lo,
    output logic [BOUND_W-1:0] win_hi,
    output logic               klock
);
    logic       glock_q, klock_q, priv_q;
    logic       acc_ok, wr_ok, cfg_ok;
    logic [5:0] widx;
    logic [DATA_W-1:0] rd_mux;

    // decode access permissions
    always_comb begin
        widx   = reg_addr[7:2];
        acc_ok = !(priv_q && !reg_priv);
        wr_ok  = reg_wr && acc_ok;
        cfg_ok = wr_ok && !glock_q;
        key_wr = cfg_ok && !klock_q && (widx[5:2] == W_KEY0[5:2]);
        key_sel = widx[1:0];
    end

    // set-only lock bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glock_q <= 1'b0;
            klock_q <= 1'b0;
        end else if (wr_ok && widx == W_CTRL) begin
            glock_q <= glock_q | reg_wdata[B_GLOCK];
            klock_q <= klock_q | reg_wdata[B_KLOCK];
        end
    end

    // window and privilege configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q  <= 1'b0;
            win_en  <= 1'b0;
            win_enc <= 1'b0;
            win_lo  <= '0;
            win_hi  <= '0;
        end else if (cfg_ok) begin
            case (widx)
                W_PRIV: priv_q <= reg_wdata[B_PRIV];
                W_WCTL: begin
                    win_en  <= reg_wdata[B_WEN];
                    win_enc <= reg_wdata[B_WENC];
                end
                W_WLO:  win_lo <= reg_wdata[DATA_W-1:BOUND_LSB];
                W_WHI:  win_hi <= reg_wdata[DATA_W-1:BOUND_LSB];
                default: ;
            endcase
        end
    end

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        case (widx)
            W_CTRL: begin
                rd_mux[B_GLOCK] = glock_q;
                rd_mux[B_KLOCK] = klock_q;
            end
            W_STAT: begin
                rd_mux[B_KVALID] = key_valid;
                rd_mux[B_ENCOFF] = enc_off;
            end
            W_PRIV: rd_mux[B_PRIV] = priv_q;
            W_WCTL: begin
                rd_mux[B_WEN]  = win_en;
                rd_mux[B_WENC] = win_enc;
            end
            W_WLO:  rd_mux = {2'b00, win_lo[BOUND_W-3:0], {BOUND_LSB{1'b0}}};
            W_WHI:  rd_mux = {2'b00, win_hi[BOUND_W-3:0], {BOUND_LSB{1'b0}}};
            default: ;
        endcase
    end

    // registered read data, zero for refused reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= acc_ok ? rd_mux : '0;
    end

    assign klock = klock_q;

    // R1
    glock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glock_q |=> glock_q);
    // R1
    klock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        klock_q |=> klock_q);
    // R10
    unpriv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && priv_q && !reg_priv) |=> (reg_rdata == '0));
    // R11
    glock_window_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glock_q |=> ($stable(win_lo) && $stable(win_hi) && $stable(win_en) && $stable(priv_q)));
endmodule

// File: rtl/mem_crypt_region_ctrl.sv
// Module: top of the memory encryption region controller. Joins the
// register bank, the key store and the window classifier.
// Assumes enc_off is a static hardware status input.
module mem_crypt_region_ctrl
    import mcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic                        reg_priv,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic                        enc_off,
    input  logic [DATA_W-1:0]           lk_addr,
    output logic                        lk_encrypt,
    output logic [KEY_WORDS*DATA_W-1:0] master_key
);
    logic               key_valid, key_wr, win_en, win_enc, klock, active;
    logic [1:0]         key_sel;
    logic [BOUND_W-1:0] win_lo, win_hi;

    mcr_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_priv(reg_priv), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .enc_off(enc_off), .key_valid(key_valid),
        .key_wr(key_wr), .key_sel(key_sel), .win_en(win_en), .win_enc(win_enc),
        .win_lo(win_lo), .win_hi(win_hi), .klock(klock)
    );

    mcr_keystore #(.KEY_WORDS(KEY_WORDS), .DATA_W(DATA_W)) u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(key_wr), .word_sel(key_sel),
        .wdata(reg_wdata), .key(master_key), .valid(key_valid)
    );

    // window is usable only when enabled, encrypting and not fused off
    assign active = win_en && win_enc && !enc_off;

    mcr_region_match #(.ADDR_W(DATA_W), .BOUND_LSB(BOUND_LSB)) u_match (
        .addr(lk_addr), .lo(win_lo), .hi(win_hi), .active(active), .hit(lk_encrypt)
    );

    // R9
    klock_key_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        klock |=> ($stable(master_key) && $stable(key_valid)));
    // R6
    fuse_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_off |-> !lk_encrypt);
endmodule

// File: tb/mem_crypt_region_ctrl_test.sv
module mem_crypt_region_ctrl_test;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0, rst_n = 1'b0;
    logic         reg_wr = 0, reg_rd = 0, reg_priv = 1, enc_off = 0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0, reg_rdata, lk_addr = '0;
    logic         lk_encrypt;
    logic [127:0] master_key;
    int n_chk = 0, n_fail = 0;

    mem_crypt_region_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_priv(reg_priv), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .enc_off(enc_off), .lk_addr(lk_addr),
        .lk_encrypt(lk_encrypt), .master_key(master_key)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {expected, address} with window 0x8001..0x8003
    localparam logic [32:0] VEC [8] = '{
        {1'b0, 32'h8000_FFFF}, {1'b1, 32'h8001_0000}, {1'b1, 32'h8002_5555},
        {1'b1, 32'h8003_FFFF}, {1'b0, 32'h8004_0000}, {1'b0, 32'h0002_0000},
        {1'b0, 32'hC002_0000}, {1'b0, 32'h4002_0000}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic look(input logic [31:0] a, output logic e);
        @(negedge clk); lk_addr = a; #1; e = lk_encrypt;
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        rd(8'h00, d); check("R1 reset ctrl", d, 0);
        rd(8'h04, d); check("R8 reset status", d, 0);
        look(32'h0000_0000, e); check("R6 reset lookup", e, 0);

        // window setup and read-back
        wr(8'h14, 32'hC001_1234);
        wr(8'h18, 32'hC003_ABCD);
        rd(8'h14, d); check("R4 low readback", d, 32'h0001_0000);
        rd(8'h18, d); check("R4 high readback", d, 32'h0003_0000);
        wr(8'h14, 32'h8001_0000);
        wr(8'h18, 32'h8003_0000);
        wr(8'h10, 32'h0000_8001);
        rd(8'h10, d); check("R3 window ctl", d, 32'h0000_8001);
        foreach (VEC[i]) begin
            look(VEC[i][31:0], e);
            check($sformatf("R5 lookup %0h", VEC[i][31:0]), e, VEC[i][32]);
        end
        // gating conditions
        wr(8'h10, 32'h0000_8000); look(32'h8002_0000, e); check("R6 enable off", e, 0);
        wr(8'h10, 32'h0000_0001); look(32'h8002_0000, e); check("R6 select off", e, 0);
        wr(8'h10, 32'h0000_8001); look(32'h8002_0000, e); check("R5 restored", e, 1);
        @(negedge clk); enc_off = 1; #1; check("R6 fuse off", lk_encrypt, 0);
        rd(8'h04, d); check("R2 status encoff", d, 32'h10);
        @(negedge clk); enc_off = 0;

        // key sequence
        wr(8'h20, 32'h1111_1111); wr(8'h24, 32'h2222_2222); wr(8'h28, 32'h3333_3333);
        rd(8'h04, d); check("R7 three words", d, 0);
        wr(8'h2C, 32'h4444_4444);
        rd(8'h04, d); check("R7 four words valid", d, 1);
        check("R7 key value", master_key, 128'h44444444_33333333_22222222_11111111);
        rd(8'h20, d); check("R7 key read zero", d, 0);
        wr(8'h24, 32'hAAAA_AAAA);
        rd(8'h04, d); check("R8 restart drops", d, 0);
        wr(8'h20, 32'h5); wr(8'h28, 32'h6); wr(8'h2C, 32'h7);
        rd(8'h04, d); check("R8 revalid", d, 1);
        // key lock
        wr(8'h00, 32'h2);
        wr(8'h20, 32'hDEAD_BEEF);
        check("R9 key frozen", master_key, 128'h00000007_00000006_AAAAAAAA_00000005);
        rd(8'h04, d); check("R9 valid kept", d, 1);
        wr(8'h00, 32'h0);
        rd(8'h00, d); check("R1 set only", d, 2);

        // privilege
        wr(8'h0C, 32'h1);
        @(negedge clk); reg_priv = 0;
        wr(8'h10, 32'h0);
        rd(8'h10, d); check("R10 unpriv read zero", d, 0);
        @(negedge clk); reg_priv = 1;
        rd(8'h10, d); check("R10 unpriv write ignored", d, 32'h0000_8001);

        // global lock
        wr(8'h00, 32'h1);
        wr(8'h14, 32'h8005_0000);
        wr(8'h0C, 32'h0);
        rd(8'h14, d); check("R11 low frozen", d, 32'h0001_0000);
        rd(8'h0C, d); check("R11 priv frozen", d, 1);
        rd(8'h00, d); check("R1 both locks", d, 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule